// File: doc/BRIEF.md
# Dual Accumulator Read Scaler with Saturation

This block sits between a wide accumulator and two narrow data buses. On each read it takes a 56-bit two's-complement accumulator value, picks a 24-bit window out of it according to a shared scaling mode, and registers the result onto the bus. The window can be the plain upper word or the word scaled by one bit in either direction. Software changes the mode once per pass, and every later read is scaled with no extra instruction. This suits block floating-point work, such as scaling each pass of a transform.

When the chosen window cannot represent the value, the bus word is clamped to the largest positive or most negative 24-bit value. The lane reports the event for that read, and a shared sticky flag records that clamping has happened at least once. The two lanes work independently and in parallel. They share the scaling mode and the sticky flag. The flag stays set until an explicit clear.

Top module: `acc_rdscale_dual`

## Requirements
- R1: During and right after a synchronous active-high reset, every `bus_out` lane is 0, `bus_vld` is 0, `lim_evt` is 0 and `lim_sticky` is 0.
- R2: With `scale_mode` = 2'b00 and `rd_en[i]` high, the edge registers bits [47:24] of lane i's accumulator onto lane i of `bus_out`, and `bus_vld[i]` is 1 in the following cycle.
- R3: With `scale_mode` = 2'b01 (scale down), the registered word is bits [48:25], which is the value shifted right by one.
- R4: With `scale_mode` = 2'b10 (scale up), the registered word is bits [46:23], which is the value shifted left by one.
- R5: `scale_mode` = 2'b11 behaves exactly like 2'b00.
- R6: When the accumulator bits above the selected window are not all equal to the window's top bit and bit 55 is 0, the lane outputs 24'h7FFFFF and its `lim_evt` bit is 1 in the same cycle as the word.
- R7: In the same out-of-range case with bit 55 equal to 1, the lane outputs 24'h800000 and `lim_evt` is 1.
- R8: `lim_sticky` rises with the first clamped read on either lane and stays 1 while `lim_clr` is low.
- R9: `lim_clr` clears `lim_sticky` at the next edge, unless a clamped read lands on that same edge, in which case the flag stays 1.
- R10: With `rd_en[i]` low, lane i holds its previous word, and `bus_vld[i]` and `lim_evt[i]` are 0 in the next cycle. Each lane uses only its own accumulator input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scale_mode | input | 2 | Shared scaling mode: 00 none, 01 down, 10 up, 11 treated as none |
| rd_en | input | NUM_LANES | Read strobe per lane |
| acc_in | input | NUM_LANES*ACC_W | Accumulator value per lane; lane i at bits [i*ACC_W +: ACC_W] |
| lim_clr | input | 1 | Clears the sticky limit flag |
| bus_out | output | NUM_LANES*BUS_W | Registered bus word per lane |
| bus_vld | output | NUM_LANES | Lane word was loaded at the last edge |
| lim_evt | output | NUM_LANES | Lane word loaded at the last edge was clamped |
| lim_sticky | output | 1 | Sticky record of any clamped read |

## Verification
A clamped read and a clear of the sticky flag can arrive on the same clock edge. The bench first sets the flag. It then asserts `lim_clr` in the same cycle as an out-of-range read on the second lane, and it expects the flag to remain set. A clear with only in-range reads, and a clear with no reads, must both drop the flag. The two lanes saturating in opposite directions within one cycle is also covered, with each lane's word and event bit judged separately.

// File: rtl/acs_pkg.sv
package acs_pkg;

  typedef enum logic [1:0] {
    SCL_NONE = 2'b00,
    SCL_DOWN = 2'b01,
    SCL_UP   = 2'b10,
    SCL_RSVD = 2'b11
  } scale_e;

  // Offset of the selected window relative to the unscaled window.
  function automatic int win_delta(scale_e m);
    case (m)
      SCL_DOWN: win_delta = 1;
      SCL_UP:   win_delta = -1;
      default:  win_delta = 0;
    endcase
  endfunction

endpackage

// File: rtl/acs_window.sv
module acs_window
  import acs_pkg::*;
#(
  parameter int ACC_W = 56,
  parameter int EXT_W = 8,
  parameter int BUS_W = 24
) (
  input  logic [ACC_W-1:0] acc,
  input  scale_e           mode,
  output logic [BUS_W-1:0] word,
  output logic             out_of_range
);
  localparam int BASE = ACC_W - EXT_W - BUS_W;
  localparam logic [BUS_W-1:0] SAT_POS = {1'b0, {(BUS_W-1){1'b1}}};
  localparam logic [BUS_W-1:0] SAT_NEG = {1'b1, {(BUS_W-1){1'b0}}};

  int                      lo;
  logic signed [ACC_W-1:0] acc_s;
  logic signed [ACC_W-1:0] guard;
  logic [BUS_W-1:0]        raw;

  always_comb begin
    lo    = BASE + win_delta(mode);
    acc_s = acc;
    // Guard bits: everything from the window sign bit upward.
    guard = acc_s >>> (lo + BUS_W - 1);
    raw   = acc[lo +: BUS_W];
    out_of_range = !((guard == '0) || (&guard));
    if (out_of_range)
      word = acc[ACC_W-1] ? SAT_NEG : SAT_POS;
    else
      word = raw;
  end
endmodule

// File: rtl/acs_lane.sv
module acs_lane
  import acs_pkg::*;
#(
  parameter int ACC_W = 56,
  parameter int EXT_W = 8,
  parameter int BUS_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  scale_e           mode,
  input  logic             rd,
  input  logic [ACC_W-1:0] acc,
  output logic [BUS_W-1:0] word_q,
  output logic             vld_q,
  output logic             evt_q,
  output logic             hit
);
  logic [BUS_W-1:0] word_d;
  logic             oor;

  acs_window #(.ACC_W(ACC_W), .EXT_W(EXT_W), .BUS_W(BUS_W)) u_win (
    .acc          (acc),
    .mode         (mode),
    .word         (word_d),
    .out_of_range (oor)
  );

  assign hit = rd & oor;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      vld_q  <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      vld_q <= rd;
      evt_q <= hit;
      if (rd) word_q <= word_d;
    end
  end
endmodule

// File: rtl/acs_sticky.sv
module acs_sticky #(
  parameter int NUM_LANES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic [NUM_LANES-1:0] hits,
  output logic                 flag
);
  // A new hit outranks a clear on the same edge.
  always_ff @(posedge clk) begin
    if (rst)        flag <= 1'b0;
    else if (|hits) flag <= 1'b1;
    else if (clr)   flag <= 1'b0;
  end
endmodule

// File: rtl/acc_rdscale_dual.sv
module acc_rdscale_dual
  import acs_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int ACC_W     = 56,
  parameter int EXT_W     = 8,
  parameter int BUS_W     = 24
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [1:0]                     scale_mode,
  input  logic [NUM_LANES-1:0]           rd_en,
  input  logic [NUM_LANES*ACC_W-1:0]     acc_in,
  input  logic                           lim_clr,
  output logic [NUM_LANES*BUS_W-1:0]     bus_out,
  output logic [NUM_LANES-1:0]           bus_vld,
  output logic [NUM_LANES-1:0]           lim_evt,
  output logic                           lim_sticky
);
  scale_e               mode;
  logic [NUM_LANES-1:0] hits;

  assign mode = scale_e'(scale_mode);

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    acs_lane #(.ACC_W(ACC_W), .EXT_W(EXT_W), .BUS_W(BUS_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .mode   (mode),
      .rd     (rd_en[i]),
      .acc    (acc_in[i*ACC_W +: ACC_W]),
      .word_q (bus_out[i*BUS_W +: BUS_W]),
      .vld_q  (bus_vld[i]),
      .evt_q  (lim_evt[i]),
      .hit    (hits[i])
    );
  end

  acs_sticky #(.NUM_LANES(NUM_LANES)) u_sticky (
    .clk  (clk),
    .rst  (rst),
    .clr  (lim_clr),
    .hits (hits),
    .flag (lim_sticky)
  );
endmodule

// File: rtl/acs_checker.sv
module acs_checker #(
  parameter int NUM_LANES = 2,
  parameter int BUS_W     = 24
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_LANES-1:0]       rd_en,
  input logic                       lim_clr,
  input logic [NUM_LANES*BUS_W-1:0] bus_out,
  input logic [NUM_LANES-1:0]       bus_vld,
  input logic [NUM_LANES-1:0]       lim_evt,
  input logic                       lim_sticky
);
  localparam logic [BUS_W-1:0] SAT_POS = {1'b0, {(BUS_W-1){1'b1}}};
  localparam logic [BUS_W-1:0] SAT_NEG = {1'b1, {(BUS_W-1){1'b0}}};

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!lim_sticky && bus_vld == '0 && lim_evt == '0));

  p_sticky_set_r8: assert property (@(posedge clk) disable iff (rst)
    (|lim_evt) |-> lim_sticky);

  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (lim_sticky && !lim_clr) |=> lim_sticky);

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    lim_clr |=> (lim_sticky == (|lim_evt)));

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_chk
    p_sat_value_r6: assert property (@(posedge clk) disable iff (rst)
      lim_evt[i] |-> (bus_out[i*BUS_W +: BUS_W] == SAT_POS ||
                      bus_out[i*BUS_W +: BUS_W] == SAT_NEG));

    p_vld_r2: assert property (@(posedge clk) disable iff (rst)
      rd_en[i] |=> bus_vld[i]);

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
      !rd_en[i] |=> (!bus_vld[i] && !lim_evt[i] &&
                     $stable(bus_out[i*BUS_W +: BUS_W])));
  end
endmodule

bind acc_rdscale_dual acs_checker #(.NUM_LANES(NUM_LANES), .BUS_W(BUS_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_en      (rd_en),
  .lim_clr    (lim_clr),
  .bus_out    (bus_out),
  .bus_vld    (bus_vld),
  .lim_evt    (lim_evt),
  .lim_sticky (lim_sticky)
);

// File: tb/sim_acc_rdscale_dual.sv
`timescale 1ns/1ps
module sim_acc_rdscale_dual;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   scale_mode = 2'b00;
  logic [1:0]   rd_en = 2'b00;
  logic [111:0] acc_in = '0;
  logic         lim_clr = 1'b0;
  logic [47:0]  bus_out;
  logic [1:0]   bus_vld;
  logic [1:0]   lim_evt;
  logic         lim_sticky;

  int checks = 0;
  int errors = 0;
  logic [23:0] prev_w [2];
  logic        exp_st = 1'b0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  acc_rdscale_dual u0 (
    .clk(clk), .rst(rst), .scale_mode(scale_mode), .rd_en(rd_en),
    .acc_in(acc_in), .lim_clr(lim_clr), .bus_out(bus_out),
    .bus_vld(bus_vld), .lim_evt(lim_evt), .lim_sticky(lim_sticky)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Model built from the requirement text: scaled integer value, then range test.
  function automatic logic [23:0] model(input logic [55:0] a, input logic [1:0] m, output logic ov);
    longint v = longint'($signed(a));
    longint q;
    if (m == 2'b01)      q = v >>> 25;
    else if (m == 2'b10) q = v >>> 23;
    else                 q = v >>> 24;
    ov = 1'b0;
    if (q > 64'sd8388607)       begin ov = 1'b1; model = 24'h7FFFFF; end
    else if (q < -64'sd8388608) begin ov = 1'b1; model = 24'h800000; end
    else model = q[23:0];
  endfunction

  task automatic apply(input logic [55:0] a0, input logic [55:0] a1, input logic [1:0] rd,
                       input logic [1:0] m, input logic clr, input string tag);
    logic ov [2];
    logic [23:0] w [2];
    @(negedge clk);
    acc_in = {a1, a0}; rd_en = rd; scale_mode = m; lim_clr = clr;
    for (int i = 0; i < 2; i++) w[i] = model(i == 0 ? a0 : a1, m, ov[i]);
    @(negedge clk);
    rd_en = 2'b00; lim_clr = 1'b0;
    for (int i = 0; i < 2; i++) begin
      logic [23:0] ew = rd[i] ? w[i] : prev_w[i];
      logic        ee = rd[i] & ov[i];
      chk(bus_out[i*24 +: 24] == ew, tag, bus_out[i*24 +: 24], ew);
      chk(bus_vld[i] == rd[i], {tag, " vld R10"}, bus_vld[i], rd[i]);
      chk(lim_evt[i] == ee, {tag, " evt R6"}, lim_evt[i], ee);
      prev_w[i] = ew;
    end
    exp_st = (|(rd & {ov[1], ov[0]})) ? 1'b1 : (clr ? 1'b0 : exp_st);
    chk(lim_sticky == exp_st, {tag, " sticky R8"}, lim_sticky, exp_st);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(bus_out == '0, "R1 bus", bus_out[31:0], 0);
    chk(bus_vld == '0 && lim_evt == '0, "R1 flags", {bus_vld, lim_evt}, 0);
    chk(lim_sticky == 1'b0, "R1 sticky", lim_sticky, 0);
    rst = 1'b0;
    prev_w[0] = '0; prev_w[1] = '0; exp_st = 1'b0;
  endtask

  task automatic t_modes;
    apply(56'h00_123456_789ABC, 56'hFF_C00000_000000, 2'b11, 2'b00, 1'b0, "R2 none");
    apply(56'h00_123456_789ABC, 56'hFF_C00001_800000, 2'b11, 2'b01, 1'b0, "R3 down");
    apply(56'h00_FFFFFF_000000, 56'h00_000000_FFFFFF, 2'b11, 2'b01, 1'b0, "R3 down edge");
    apply(56'h00_123456_789ABC, 56'hFF_E00000_800000, 2'b11, 2'b10, 1'b0, "R4 up");
    apply(56'h00_3FFFFF_800000, 56'hFF_C00000_000000, 2'b11, 2'b10, 1'b0, "R4 up edge");
    apply(56'h00_123456_789ABC, 56'hFF_ABCDEF_000000, 2'b11, 2'b11, 1'b0, "R5 reserved");
  endtask

  task automatic t_idle;
    apply(56'h01_000000_000000, 56'hFE_000000_000000, 2'b00, 2'b00, 1'b0, "R10 idle");
    apply(56'h00_111111_000000, 56'h01_000000_000000, 2'b01, 2'b00, 1'b0, "R10 lane0 only");
  endtask

  task automatic t_saturate;
    apply(56'h01_000000_000000, 56'hFE_FFFFFF_000000, 2'b11, 2'b00, 1'b0, "R6 R7 both");
    apply(56'h00_400000_000000, 56'hFF_BFFFFF_000000, 2'b11, 2'b10, 1'b0, "R6 R7 up");
    apply(56'h00_800000_000000, 56'hFF_7FFFFF_000000, 2'b11, 2'b00, 1'b0, "R6 R7 ext");
    apply(56'h01_FFFFFF_000000, 56'hFE_000000_000000, 2'b11, 2'b01, 1'b0, "R6 R7 down");
  endtask

  task automatic t_sticky;
    apply(56'h00_000001_000000, 56'h00_000002_000000, 2'b11, 2'b00, 1'b0, "R8 hold");
    apply(56'h00_000001_000000, 56'h00_000002_000000, 2'b11, 2'b00, 1'b1, "R9 clear w/ reads");
    apply(56'h01_000000_000000, 56'h0, 2'b01, 2'b00, 1'b0, "R8 set lane0");
    apply(56'h0, 56'h0, 2'b00, 2'b00, 1'b1, "R9 clear idle");
    apply(56'h0, 56'hFE_000000_000000, 2'b10, 2'b00, 1'b0, "R8 set lane1");
    apply(56'h0, 56'hFE_000000_000000, 2'b10, 2'b00, 1'b1, "R9 collide");
    apply(56'h0, 56'h0, 2'b00, 2'b00, 1'b1, "R9 clear after collide");
  endtask

  task automatic t_sweep;
    logic [55:0] s = 56'h5A_3C96_1234_ABCD;
    for (int k = 0; k < 40; k++) begin
      logic [55:0] a0, a1;
      s = {s[54:0], s[55] ^ s[54] ^ s[52] ^ s[48]};
      a0 = (k % 3 == 0) ? s : {{8{s[47]}}, s[47:0]};
      a1 = {{9{s[20]}}, s[46:0] ^ 47'h1234_5678_9ABC};
      apply(a0, a1, 2'(k % 4) | 2'b01, 2'(k), 1'(k % 7 == 0), "R2 R3 R4 R5 sweep");
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_modes;
    t_idle;
    t_saturate;
    t_sticky;
    t_sweep;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule